// File: doc/BRIEF.md
# Transition-Minimising Bus Inversion Codec

This block sits between a 64-bit datapath and a set of active-low bus wires. It limits how many wires switch from one transfer to the next. The bus is cut into four 16-bit lanes, and each lane has its own inversion flag wire.

On the sending side, the block looks at each lane's next word and counts how many wires would change level compared with what the lane last drove. If that count is above half the lane width, the lane is sent with its polarity flipped and its flag is raised. The value it then drives becomes the new reference for the next decision. On the receiving side, the block uses the flags to undo the flip and return the true data.

A valid strobe marks every transfer in both directions. Cycles without the strobe leave the wires and the reference untouched.

Top module: `dbi_codec`

## Requirements
- R1: While rst_n is low and after its release, before any transfer, bus_data_n and bus_inv_n are all ones (deasserted), bus_valid and rx_out_valid are 0, and rx_out_data is 0.
- R2: A word presented with tx_valid high appears on bus_data_n/bus_inv_n with bus_valid high exactly one clock later.
- R3: Flag bit g of bus_inv_n (and of rx_inv_n) governs data bits 16g+15 down to 16g, for g = 0..3. Each lane is decided independently.
- R4: When more than 8 wires of a lane would change, the lane is sent inverted. Its flag wire is driven low and its wires carry the true data bits unchanged, because inversion and active-low cancel.
- R5: When 8 or fewer wires of a lane would change (exactly 8 included), the lane is sent as is. Its flag wire stays high and its wires carry the bitwise complement of the data (active-low).
- R6: The toggle count compares the non-inverted wire image (~data) of a lane with the wire value that lane last drove, including any inversion applied then.
- R7: In a cycle with tx_valid low, bus_valid goes low one clock later, and bus_data_n and bus_inv_n keep their previous values.
- R8: Between two consecutive valid transfers, no lane shows more than 8 changed wires on bus_data_n.
- R9: The receive side registers its result. One clock after rx_valid is high, rx_out_valid is high and rx_out_data holds the recovered data: rx_data_n for lanes whose rx_inv_n bit is 0, and ~rx_data_n for lanes whose bit is 1. After an idle receive cycle, rx_out_valid is 0 and rx_out_data holds its last value.
- R10: With the bus outputs looped back to the receive inputs, rx_out_data equals the tx_data of each transfer, two clocks after that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_valid | input | 1 | Transmit word is valid this cycle |
| tx_data | input | 64 | Transmit word, true polarity |
| bus_valid | output | 1 | A new word is on the wires |
| bus_data_n | output | 64 | Active-low data wires |
| bus_inv_n | output | 4 | Active-low per-lane inversion flags |
| rx_valid | input | 1 | Receive wires hold a valid word |
| rx_data_n | input | 64 | Active-low received data wires |
| rx_inv_n | input | 4 | Active-low received inversion flags |
| rx_out_valid | output | 1 | Recovered word is valid |
| rx_out_data | output | 64 | Recovered word, true polarity |

## Verification
The properties assume that tx_data and the receive inputs are stable around the clock edge and that reset is held for at least one edge, so that the wire register starts at all ones. The lane transition bound relies on the wire register changing only on transfers. The stimulus changes inputs only on the falling edge. It mixes random words with words built near the 8-toggle threshold (complements and single-bit edits of the previous wire image), so that both sides of the inversion rule are exercised.

// File: rtl/dbi_pkg.sv
// Shared sizing for the bus inversion codec.
// Assumes the bus width is a whole multiple of the lane width.
package dbi_pkg;
    localparam int BUS_W  = 64;
    localparam int LANE_W = 16;
    localparam int LANES  = BUS_W / LANE_W;
endpackage

// File: rtl/dbi_lane_enc.sv
// One transmit lane: counts wire changes against its stored wire image
// and flips the lane when more than half of its wires would toggle.
// Assumes data is sampled on the rising edge; the wire image is held
// between transfers and is the lane's visible output.
module dbi_lane_enc #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         vld,
    input  logic [W-1:0] data,
    output logic [W-1:0] wire_q,
    output logic         inv_n_q
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  cand;
    logic [W-1:0]  diff;
    logic [CW-1:0] toggles;
    logic          flip;

    // Count toggles of the plain wire image against the last driven image.
    always_comb begin
        cand    = ~data;
        diff    = cand ^ wire_q;
        toggles = '0;
        for (int i = 0; i < W; i++) begin
            toggles = toggles + CW'(diff[i]);
        end
        flip = (toggles > CW'(W / 2));
    end

    // Drive the chosen image and flag; hold both on idle cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wire_q  <= '1;
            inv_n_q <= 1'b1;
        end else if (vld) begin
            wire_q  <= flip ? data : cand;
            inv_n_q <= ~flip;
        end
    end
endmodule

// File: rtl/dbi_lane_dec.sv
// One receive lane: restores true polarity from active-low wires and an
// active-low flag. Purely combinational; the top module registers it.
module dbi_lane_dec #(
    parameter int W = 16
) (
    input  logic [W-1:0] wire_n,
    input  logic         inv_n,
    output logic [W-1:0] data
);
    // A low flag means inversion cancelled the active-low coding.
    always_comb begin
        data = inv_n ? ~wire_n : wire_n;
    end
endmodule

// File: rtl/dbi_codec.sv
// Bus inversion codec top: one encoder and one decoder lane per 16-bit
// lane. The transmit path has one register stage (the wire image); the
// receive path has one register stage on the recovered word.
// Assumes a synchronous active-low reset held for at least one edge.
module dbi_codec #(
    parameter int DATA_W = dbi_pkg::BUS_W,
    parameter int GRP_W  = dbi_pkg::LANE_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tx_valid,
    input  logic [DATA_W-1:0]         tx_data,
    output logic                      bus_valid,
    output logic [DATA_W-1:0]         bus_data_n,
    output logic [DATA_W/GRP_W-1:0]   bus_inv_n,
    input  logic                      rx_valid,
    input  logic [DATA_W-1:0]         rx_data_n,
    input  logic [DATA_W/GRP_W-1:0]   rx_inv_n,
    output logic                      rx_out_valid,
    output logic [DATA_W-1:0]         rx_out_data
);
    localparam int NG = DATA_W / GRP_W;

    logic [DATA_W-1:0] dec_word;

    for (genvar g = 0; g < NG; g++) begin : g_lane
        dbi_lane_enc #(.W(GRP_W)) u_enc (
            .clk     (clk),
            .rst_n   (rst_n),
            .vld     (tx_valid),
            .data    (tx_data[g*GRP_W +: GRP_W]),
            .wire_q  (bus_data_n[g*GRP_W +: GRP_W]),
            .inv_n_q (bus_inv_n[g])
        );
        dbi_lane_dec #(.W(GRP_W)) u_dec (
            .wire_n (rx_data_n[g*GRP_W +: GRP_W]),
            .inv_n  (rx_inv_n[g]),
            .data   (dec_word[g*GRP_W +: GRP_W])
        );
    end

    // Transmit strobe follows the wire register by one stage.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_valid <= 1'b0;
        else        bus_valid <= tx_valid;
    end

    // Register the recovered word; hold data across idle cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_out_valid <= 1'b0;
            rx_out_data  <= '0;
        end else begin
            rx_out_valid <= rx_valid;
            if (rx_valid) rx_out_data <= dec_word;
        end
    end
endmodule

// File: rtl/dbi_codec_chk.sv
// Property checker for dbi_codec, attached by bind below.
// Assumes inputs settle away from the rising edge.
module dbi_codec_chk #(
    parameter int DATA_W = 64,
    parameter int GRP_W  = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    tx_valid,
    input logic [DATA_W-1:0]       tx_data,
    input logic                    bus_valid,
    input logic [DATA_W-1:0]       bus_data_n,
    input logic [DATA_W/GRP_W-1:0] bus_inv_n,
    input logic                    rx_valid,
    input logic                    rx_out_valid
);
    localparam int NG = DATA_W / GRP_W;

    AST_TX_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |=> bus_valid); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_valid |=> ($stable(bus_data_n) && $stable(bus_inv_n) && !bus_valid)); // R7

    AST_RX_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> rx_out_valid); // R9

    for (genvar g = 0; g < NG; g++) begin : g_chk
        AST_LANE_TOGGLE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(bus_valid) || bus_valid |->
            $countones(bus_data_n[g*GRP_W +: GRP_W] ^ $past(bus_data_n[g*GRP_W +: GRP_W])) <= GRP_W/2); // R8

        AST_LANE_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
            tx_valid |=> (bus_inv_n[g] ? (bus_data_n[g*GRP_W +: GRP_W] == ~$past(tx_data[g*GRP_W +: GRP_W]))
                                       : (bus_data_n[g*GRP_W +: GRP_W] ==  $past(tx_data[g*GRP_W +: GRP_W])))); // R4
    end
endmodule

bind dbi_codec dbi_codec_chk #(.DATA_W(DATA_W), .GRP_W(GRP_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_valid     (tx_valid),
    .tx_data      (tx_data),
    .bus_valid    (bus_valid),
    .bus_data_n   (bus_data_n),
    .bus_inv_n    (bus_inv_n),
    .rx_valid     (rx_valid),
    .rx_out_valid (rx_out_valid)
);

// File: tb/dbi_codec_test.sv
`timescale 1ns/1ps
module dbi_codec_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_valid = 1'b0;
    logic [63:0] tx_data = '0;
    logic        bus_valid;
    logic [63:0] bus_data_n;
    logic [3:0]  bus_inv_n;
    logic        rx_out_valid;
    logic [63:0] rx_out_data;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // Model state
    logic [63:0] m_wire = '1;
    logic [3:0]  m_inv_n = '1;
    logic [63:0] prev_obs = '1;
    bit          prev_v = 0;
    logic [63:0] prev_d = '0;
    logic [63:0] held_d = '0;

    always #2 clk = ~clk;

    dbi_codec uut (
        .clk(clk), .rst_n(rst_n),
        .tx_valid(tx_valid), .tx_data(tx_data),
        .bus_valid(bus_valid), .bus_data_n(bus_data_n), .bus_inv_n(bus_inv_n),
        .rx_valid(bus_valid), .rx_data_n(bus_data_n), .rx_inv_n(bus_inv_n),
        .rx_out_valid(rx_out_valid), .rx_out_data(rx_out_data)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic int ones16(input logic [15:0] v);
        int c = 0;
        for (int i = 0; i < 16; i++) c += int'(v[i]);
        return c;
    endfunction

    // Update the model wire image for one valid word (R4 R5 R6)
    task automatic model_send(input logic [63:0] d);
        for (int g = 0; g < 4; g++) begin
            logic [15:0] cand;
            cand = ~d[g*16 +: 16];
            if (ones16(cand ^ m_wire[g*16 +: 16]) > 8) begin
                m_wire[g*16 +: 16] = d[g*16 +: 16];
                m_inv_n[g] = 1'b0;
            end else begin
                m_wire[g*16 +: 16] = cand;
                m_inv_n[g] = 1'b1;
            end
        end
    endtask

    task automatic step(input bit v, input logic [63:0] d);
        tx_valid = v;
        tx_data  = d;
        @(posedge clk);
        @(negedge clk);
        if (v) model_send(d);
        check(bus_valid == v, "R2/R7 bus_valid", 64'(bus_valid), 64'(v));
        check(bus_data_n == m_wire, "R4/R5/R6 bus_data_n", bus_data_n, m_wire);
        check(bus_inv_n == m_inv_n, "R3 bus_inv_n", 64'(bus_inv_n), 64'(m_inv_n));
        for (int g = 0; g < 4; g++) begin
            int t;
            t = ones16(bus_data_n[g*16 +: 16] ^ prev_obs[g*16 +: 16]);
            check(t <= 8, "R8 lane toggles", 64'(t), 64'd8);
        end
        prev_obs = bus_data_n;
        check(rx_out_valid == prev_v, "R9 rx_out_valid", 64'(rx_out_valid), 64'(prev_v));
        if (prev_v) held_d = prev_d;
        check(rx_out_data == held_d, "R10/R9 rx_out_data", rx_out_data, held_d);
        prev_v = v;
        prev_d = d;
    endtask

    initial begin
        int seed;
        seed = $urandom(32'h5eed_1234);
        @(negedge clk);
        @(negedge clk);
        check(bus_data_n == '1, "R1 wires", bus_data_n, '1);
        check(bus_inv_n == '1, "R1 flags", 64'(bus_inv_n), 64'hf);
        check(!bus_valid && !rx_out_valid, "R1 valids", 64'({bus_valid, rx_out_valid}), 64'd0);
        check(rx_out_data == '0, "R1 rx data", rx_out_data, '0);
        rst_n = 1'b1;
        // Directed: from all-ones wires, toggles = popcount(data) per lane.
        // lane0 8 toggles (R5), lane1 9 (R4), lane2 16 (R4), lane3 0 (R5)
        step(1'b1, {16'h0000, 16'hFFFF, 16'h01FF, 16'h00FF});
        check(bus_inv_n == 4'b1001, "R3 directed flags", 64'(bus_inv_n), 64'h9);
        check(bus_data_n[15:0] == 16'hFF00, "R5 exactly eight", 64'(bus_data_n[15:0]), 64'hFF00);
        check(bus_data_n[31:16] == 16'h01FF, "R4 nine toggles", 64'(bus_data_n[31:16]), 64'h01FF);
        // Idle: hold (R7), then same word again re-decided against held image (R6)
        step(1'b0, 64'hDEAD_BEEF_0123_4567);
        step(1'b0, '0);
        step(1'b1, {16'h0000, 16'hFFFF, 16'h01FF, 16'h00FF});
        step(1'b1, '0);
        step(1'b1, '1);
        // Random mix with threshold-biased words
        for (int n = 0; n < 3000; n++) begin
            logic [63:0] d;
            int k;
            k = $urandom_range(0, 3);
            if (k == 0) d = {$urandom, $urandom};
            else if (k == 1) d = m_wire;
            else if (k == 2) d = ~m_wire ^ (64'd1 << $urandom_range(0, 63));
            else d = m_wire ^ {4{16'h00FF}};
            step($urandom_range(0, 3) != 0, d);
        end
        step(1'b0, '0);
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule